// File: doc/BRIEF.md
# SPI Register-Write Command Engine

This block sits on the host side of a full-duplex SPI link to a combined MAC and PHY device. It writes a run of consecutive device registers. The caller supplies a 16-bit start address, a 4-bit memory-map selector and a register count, then pulses `start_i`. The engine builds a 32-bit control header protected by a parity bit and lowers chip-select once. Within that single chip-select window it shifts out the header, one 32-bit value for each register and a trailing word of zeros. Every word is sent most significant bit first, which puts the bytes on the wire in big-endian order. The register values come from a local buffer. The engine reads that buffer combinationally by presenting an index on `data_idx_o` and taking the word on `data_i`.

The device answers with the command echoed back one word late. The first received word carries no meaning. Each later received word must equal the word that was transmitted one slot earlier. The engine compares each received word against a single saved copy as it completes, so it never needs storage for the whole frame. At the end it raises `done_o` for one cycle. At the same moment it reports a protocol error if any echoed word differed, or a length error if the count was out of range. A length error involves no SPI activity at all.

Control state machine:
- IDLE: waits for `start_i`.
  - A valid count latches the request and moves to LOAD.
  - An invalid count moves straight to DONE.
- LOAD: hands the next word to the bit shifter, then moves to SHIFT.
- SHIFT: waits until 32 bits have been exchanged, then moves to CHECK.
- CHECK: compares the received word.
  - If more words remain, it advances the word index and returns to LOAD.
  - After the pad word it moves to FINISH.
- FINISH: releases chip-select, then moves to DONE.
- DONE: pulses `done_o` and returns to IDLE.

Top module: `spi_ctrl_writer`

## Requirements
- R1: The header transmitted first has the following fields. Bit 31 is 0, which marks a control command. Bit 29 is 1, which marks a write. Bits 30 and 28 are 0. Bits 27:24 hold the memory-map selector, bits 23:8 hold the start address, and bits 7:1 hold the count minus one.
- R2: Header bit 0 makes the total number of ones in the 32-bit header odd.
- R3: A valid request produces exactly one chip-select low window containing 32*(count+2) rising SCLK edges. The last 32 bits sent on MOSI are all zero, and chip-select is low only while the engine is busy.
- R4: Words go out most significant bit first. The data words follow the header in buffer order, and the value at index k (0-based) is sent as word k+1 of the frame.
- R5: SPI mode 0 is used. SCLK is low whenever chip-select is high. MOSI changes only while SCLK is low. MISO is sampled on the rising SCLK edge.
- R6: A count of 0 or a count above 128 produces `done_o` together with `len_err_o`, and chip-select is never asserted. Counts of 1 through 128 are accepted.
- R7: The first received word is ignored. If any received word n (n ≥ 1) differs from transmitted word n−1, `proto_err_o` is raised with `done_o`. Otherwise the transfer completes without error.
- R8: `busy_o` is high from the cycle after an accepted start until `done_o`. `done_o` lasts exactly one cycle, and both error outputs are high only while `done_o` is high.
- R9: A `start_i` pulse while `busy_o` is high is ignored. It adds no frame and no extra `done_o`.
- R10: After reset, chip-select is high, SCLK is low, and `busy_o` and `done_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Engine clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, one cycle |
| addr_i | input | 16 | First register address |
| mms_i | input | 4 | Memory-map selector |
| count_i | input | 8 | Number of registers, valid 1..128 |
| data_idx_o | output | 7 | Index of the buffer word being fetched |
| data_i | input | 32 | Buffer word at `data_idx_o` |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | One-cycle completion strobe |
| proto_err_o | output | 1 | Echo mismatch, valid with `done_o` |
| len_err_o | output | 1 | Count out of range, valid with `done_o` |
| sclk_o | output | 1 | SPI clock, idle low |
| csn_o | output | 1 | SPI chip-select, active low |
| mosi_o | output | 1 | Serial data to the device |
| miso_i | input | 1 | Serial data from the device |

## Verification
The bound checker watches the link-level rules on every cycle:
- SCLK stays low while chip-select is high.
- MOSI does not change while SCLK is high.
- Chip-select stays high while the engine is idle.
- The completion strobe lasts a single cycle, and the error flags appear only with it.
- A start with a bad count never lowers chip-select.

Header field contents, parity, frame length, the order of the data words, the zero pad, and the decision between a clean echo and a corrupted one all depend on whole frames. Only the bench scenarios show these. The bench uses a device model that echoes the frame one word late and can corrupt a chosen word.

// File: rtl/spi_cw_pkg.sv
package spi_cw_pkg;

    localparam int WORD_W = 32;
    localparam int MMS_W  = 4;
    localparam int ADDR_W = 16;
    localparam int LENF_W = 7;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_SHIFT,
        ST_CHECK,
        ST_FINISH,
        ST_DONE
    } ctl_state_t;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_LOW,
        PH_HIGH
    } phase_t;

endpackage

// File: rtl/scw_header_gen.sv
module scw_header_gen
    import spi_cw_pkg::*;
(
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [MMS_W-1:0]  mms_i,
    input  logic [LENF_W-1:0] len_m1_i,
    output logic [WORD_W-1:0] hdr_o
);

    logic [WORD_W-1:0] body;

    always_comb begin
        body        = '0;
        body[29]    = 1'b1;                 // write flag
        body[27:24] = mms_i;
        body[23:8]  = addr_i;
        body[7:1]   = len_m1_i;
        body[0]     = ~(^body[WORD_W-1:1]); // odd overall parity
        hdr_o       = body;
    end

endmodule

// File: rtl/scw_bit_shifter.sv
module scw_bit_shifter
    import spi_cw_pkg::*;
#(
    parameter int HALF_DIV = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [WORD_W-1:0] word_i,
    input  logic              miso_i,
    output logic              sclk_o,
    output logic              mosi_o,
    output logic              word_done_o,
    output logic [WORD_W-1:0] rx_word_o
);

    localparam int DIV_W = $clog2(HALF_DIV) + 1;
    localparam int BIT_W = $clog2(WORD_W);

    phase_t            phase;
    logic [DIV_W-1:0]  dcnt;
    logic [BIT_W-1:0]  bcnt;
    logic [WORD_W-1:0] tx_sh;
    logic [WORD_W-1:0] rx_sh;
    logic              sclk_q;
    logic              done_q;
    logic              half_end;

    assign half_end = (dcnt == DIV_W'(HALF_DIV - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase  <= PH_IDLE;
            dcnt   <= '0;
            bcnt   <= '0;
            tx_sh  <= '0;
            rx_sh  <= '0;
            sclk_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (phase)
                PH_IDLE: begin
                    if (load_i) begin
                        tx_sh <= word_i;
                        bcnt  <= '0;
                        dcnt  <= '0;
                        phase <= PH_LOW;
                    end
                end
                PH_LOW: begin
                    if (half_end) begin
                        dcnt   <= '0;
                        sclk_q <= 1'b1;
                        rx_sh  <= {rx_sh[WORD_W-2:0], miso_i};
                        phase  <= PH_HIGH;
                    end else begin
                        dcnt <= dcnt + 1'b1;
                    end
                end
                PH_HIGH: begin
                    if (half_end) begin
                        dcnt   <= '0;
                        sclk_q <= 1'b0;
                        if (bcnt == BIT_W'(WORD_W - 1)) begin
                            phase  <= PH_IDLE;
                            done_q <= 1'b1;
                        end else begin
                            bcnt  <= bcnt + 1'b1;
                            tx_sh <= {tx_sh[WORD_W-2:0], 1'b0};
                            phase <= PH_LOW;
                        end
                    end else begin
                        dcnt <= dcnt + 1'b1;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    assign sclk_o      = sclk_q;
    assign mosi_o      = tx_sh[WORD_W-1];
    assign word_done_o = done_q;
    assign rx_word_o   = rx_sh;

endmodule

// File: rtl/scw_echo_check.sv
module scw_echo_check
    import spi_cw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              sent_i,
    input  logic [WORD_W-1:0] sent_word_i,
    input  logic              cmp_i,
    input  logic              skip_i,
    input  logic [WORD_W-1:0] rx_word_i,
    output logic              mismatch_o
);

    logic [WORD_W-1:0] cur_q;
    logic [WORD_W-1:0] prev_q;
    logic              bad_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q  <= '0;
            prev_q <= '0;
            bad_q  <= 1'b0;
        end else begin
            if (clear_i) begin
                bad_q <= 1'b0;
            end else if (cmp_i && !skip_i && (rx_word_i != prev_q)) begin
                bad_q <= 1'b1;
            end
            if (sent_i) begin
                prev_q <= cur_q;
                cur_q  <= sent_word_i;
            end
        end
    end

    assign mismatch_o = bad_q;

endmodule

// File: rtl/spi_ctrl_writer.sv
module spi_ctrl_writer
    import spi_cw_pkg::*;
#(
    parameter int HALF_DIV = 2,
    parameter int MAX_REGS = 128,
    parameter int CNT_W    = $clog2(MAX_REGS + 2),
    parameter int IDX_W    = $clog2(MAX_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [15:0]       addr_i,
    input  logic [3:0]        mms_i,
    input  logic [CNT_W-1:0]  count_i,
    output logic [IDX_W-1:0]  data_idx_o,
    input  logic [31:0]       data_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              proto_err_o,
    output logic              len_err_o,
    output logic              sclk_o,
    output logic              csn_o,
    output logic              mosi_o,
    input  logic              miso_i
);

    ctl_state_t        state, state_nx;
    logic [ADDR_W-1:0] addr_q;
    logic [MMS_W-1:0]  mms_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  widx;
    logic              len_err_q;
    logic              count_ok;
    logic              last_word;
    logic [WORD_W-1:0] hdr;
    logic [WORD_W-1:0] tx_word;
    logic              load;
    logic              cmp;
    logic              clear;
    logic              active;
    logic              sh_mosi;
    logic              sh_done;
    logic [WORD_W-1:0] rx_word;
    logic              mismatch;

    assign count_ok  = (count_i != '0) && (count_i <= CNT_W'(MAX_REGS));
    assign last_word = (widx == cnt_q + 1'b1);

    scw_header_gen u_hdr (
        .addr_i   (addr_q),
        .mms_i    (mms_q),
        .len_m1_i (LENF_W'(cnt_q - 1'b1)),
        .hdr_o    (hdr)
    );

    always_comb begin
        if (widx == '0) begin
            tx_word = hdr;
        end else if (last_word) begin
            tx_word = '0;
        end else begin
            tx_word = data_i;
        end
    end

    scw_bit_shifter #(.HALF_DIV(HALF_DIV)) u_shift (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (load),
        .word_i      (tx_word),
        .miso_i      (miso_i),
        .sclk_o      (sclk_o),
        .mosi_o      (sh_mosi),
        .word_done_o (sh_done),
        .rx_word_o   (rx_word)
    );

    scw_echo_check u_echo (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear_i     (clear),
        .sent_i      (load),
        .sent_word_i (tx_word),
        .cmp_i       (cmp),
        .skip_i      (widx == '0),
        .rx_word_i   (rx_word),
        .mismatch_o  (mismatch)
    );

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (start_i) state_nx = count_ok ? ST_LOAD : ST_DONE;
            ST_LOAD:   state_nx = ST_SHIFT;
            ST_SHIFT:  if (sh_done) state_nx = ST_CHECK;
            ST_CHECK:  state_nx = last_word ? ST_FINISH : ST_LOAD;
            ST_FINISH: state_nx = ST_DONE;
            ST_DONE:   state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // State register and request datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            addr_q    <= '0;
            mms_q     <= '0;
            cnt_q     <= '0;
            widx      <= '0;
            len_err_q <= 1'b0;
        end else begin
            state <= state_nx;
            if (state == ST_IDLE && start_i) begin
                len_err_q <= !count_ok;
                widx      <= '0;
                if (count_ok) begin
                    addr_q <= addr_i;
                    mms_q  <= mms_i;
                    cnt_q  <= count_i;
                end
            end else if (state == ST_CHECK && !last_word) begin
                widx <= widx + 1'b1;
            end
        end
    end

    // Outputs
    always_comb begin
        active      = (state == ST_LOAD) || (state == ST_SHIFT) || (state == ST_CHECK);
        load        = (state == ST_LOAD);
        cmp         = (state == ST_CHECK);
        clear       = (state == ST_IDLE) && start_i;
        busy_o      = (state != ST_IDLE);
        done_o      = (state == ST_DONE);
        proto_err_o = done_o && mismatch;
        len_err_o   = done_o && len_err_q;
        csn_o       = !active;
        mosi_o      = active && sh_mosi;
        data_idx_o  = IDX_W'(widx - 1'b1);
    end

endmodule

// File: rtl/spi_ctrl_writer_chk.sv
module spi_ctrl_writer_chk #(
    parameter int MAX_REGS = 128,
    parameter int CNT_W    = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic [CNT_W-1:0] count_i,
    input logic             busy_o,
    input logic             done_o,
    input logic             proto_err_o,
    input logic             len_err_o,
    input logic             sclk_o,
    input logic             csn_o,
    input logic             mosi_o
);

    AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        csn_o |-> !sclk_o);  // R5

    AST_MOSI_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_o && $past(sclk_o)) |-> $stable(mosi_o));  // R5

    AST_CS_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        !csn_o |-> busy_o);  // R3

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);  // R8

    AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (proto_err_o || len_err_o) |-> done_o);  // R8

    AST_BAD_COUNT_NO_CS: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && ((count_i == '0) || (count_i > CNT_W'(MAX_REGS))))
        |=> (csn_o && done_o && len_err_o));  // R6

endmodule

bind spi_ctrl_writer spi_ctrl_writer_chk #(.MAX_REGS(MAX_REGS), .CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .count_i     (count_i),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .proto_err_o (proto_err_o),
    .len_err_o   (len_err_o),
    .sclk_o      (sclk_o),
    .csn_o       (csn_o),
    .mosi_o      (mosi_o)
);

// File: tb/spi_ctrl_writer_test.sv
module spi_ctrl_writer_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [15:0] addr_i = '0;
    logic [3:0]  mms_i = '0;
    logic [7:0]  count_i = '0;
    logic [6:0]  data_idx_o;
    logic [31:0] data_i;
    logic        busy_o, done_o, proto_err_o, len_err_o;
    logic        sclk_o, csn_o, mosi_o;
    logic        miso_i = 1'b0;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    logic [31:0] mem [128];
    assign data_i = mem[data_idx_o];

    spi_ctrl_writer uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .addr_i(addr_i),
        .mms_i(mms_i), .count_i(count_i), .data_idx_o(data_idx_o),
        .data_i(data_i), .busy_o(busy_o), .done_o(done_o),
        .proto_err_o(proto_err_o), .len_err_o(len_err_o), .sclk_o(sclk_o),
        .csn_o(csn_o), .mosi_o(mosi_o), .miso_i(miso_i)
    );

    always #2 clk = ~clk;

    // Device model: echoes the frame one word late, optional corruption
    logic [31:0] dev_in, dev_out;
    logic [31:0] sent [136];
    int dbit, dword, nbits, frames, bad_word, mosi_hi_changes;

    initial begin
        frames = 0; nbits = 0; dbit = 0; dword = 0; bad_word = 0;
        mosi_hi_changes = 0; dev_in = '0; dev_out = '0;
    end

    always @(negedge csn_o) begin
        frames++;
        nbits = 0; dbit = 0; dword = 0;
        dev_out = 32'hC3C3_5A5A;
        miso_i = dev_out[31];
    end

    always @(posedge sclk_o) if (!csn_o) begin
        dev_in = {dev_in[30:0], mosi_o};
        nbits++;
        if (nbits % 32 == 0 && nbits / 32 <= 136) sent[nbits/32 - 1] = dev_in;
    end

    always @(negedge sclk_o) if (!csn_o) begin
        dbit++;
        if (dbit == 32) begin
            dbit = 0;
            dword++;
            dev_out = dev_in ^ ((dword == bad_word) ? 32'h0000_0100 : 32'h0);
        end else begin
            dev_out = {dev_out[30:0], 1'b0};
        end
        miso_i = dev_out[31];
    end

    always @(mosi_o) if (sclk_o && !csn_o) mosi_hi_changes++;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_header(input logic [7:0] cnt,
                                               input logic [15:0] a,
                                               input logic [3:0] m);
        logic [31:0] h;
        h = {1'b0, 1'b0, 1'b1, 1'b0, m, a, 7'(cnt - 8'd1), 1'b0};
        h[0] = ($countones(h) % 2 == 0);
        return h;
    endfunction

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Start one request and wait for done; returns the flags seen with done
    task automatic run(input logic [7:0] cnt, input logic [15:0] a,
                       input logic [3:0] m, input int bad,
                       output bit seen, output bit perr, output bit lerr);
        int t;
        bad_word = bad;
        for (int j = 0; j < 128; j++) mem[j] = (32'(j + 1) * 32'h9E37_79B9) ^ {a, a};
        @(negedge clk);
        count_i = cnt; addr_i = a; mms_i = m; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        seen = 0; perr = 0; lerr = 0; t = 0;
        while (!done_o && t < 40000) begin
            @(negedge clk);
            t++;
        end
        if (done_o) begin
            seen = 1; perr = proto_err_o; lerr = len_err_o;
            @(negedge clk);
            check(!done_o, "R8", "done lasts one cycle", 32'(done_o), 32'd0);
        end
    endtask

    typedef struct packed {
        logic [7:0]  cnt;
        logic [15:0] addr;
        logic [3:0]  mms;
        logic [7:0]  bad;
        logic        len_bad;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{8'd1,   16'h0000, 4'h0, 8'd0, 1'b0},
        '{8'd3,   16'h1234, 4'hA, 8'd0, 1'b0},
        '{8'd5,   16'hFFFF, 4'hF, 8'd0, 1'b0},
        '{8'd2,   16'h0042, 4'h3, 8'd1, 1'b0},
        '{8'd4,   16'h8001, 4'h5, 8'd3, 1'b0},
        '{8'd3,   16'h00F0, 4'h1, 8'd4, 1'b0},
        '{8'd0,   16'h0101, 4'h2, 8'd0, 1'b1},
        '{8'd129, 16'h0202, 4'h4, 8'd0, 1'b1},
        '{8'd255, 16'h0303, 4'h6, 8'd0, 1'b1}
    };

    initial begin
        while (cycles < 150000) begin
            @(posedge clk);
            cycles++;
        end
        checks++; errors++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
        finish_run();
    end

    initial begin
        bit seen, perr, lerr, ok;
        int f0;
        logic [31:0] h;

        repeat (3) @(negedge clk);
        // R10: reset state
        check(csn_o == 1'b1, "R10", "csn in reset", 32'(csn_o), 32'd1);
        check(sclk_o == 1'b0, "R10", "sclk in reset", 32'(sclk_o), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy_o && !done_o, "R10", "busy/done after reset",
              {30'd0, busy_o, done_o}, 32'd0);

        // Vector table
        for (int i = 0; i < NV; i++) begin
            vec_t v;
            bit exp_p;
            v = VECS[i];
            f0 = frames;
            exp_p = !v.len_bad && (v.bad != 0);
            run(v.cnt, v.addr, v.mms, int'(v.bad), seen, perr, lerr);
            check(seen, "R8", "done seen", 32'(seen), 32'd1);
            check(lerr == v.len_bad, "R6", "length error flag", 32'(lerr), 32'(v.len_bad));
            check(perr == exp_p, "R7", "echo error flag", 32'(perr), 32'(exp_p));
            if (v.len_bad) begin
                check(frames == f0, "R6", "no chip-select on bad count", 32'(frames - f0), 32'd0);
            end else begin
                h = exp_header(v.cnt, v.addr, v.mms);
                check(frames == f0 + 1, "R3", "one frame", 32'(frames - f0), 32'd1);
                check(nbits == 32 * (v.cnt + 2), "R3", "frame bits", 32'(nbits), 32'(32 * (v.cnt + 2)));
                check(sent[0] == h, "R1", "header fields", sent[0], h);
                check($countones(sent[0]) % 2 == 1, "R2", "odd header parity",
                      32'($countones(sent[0])), 32'd1);
                ok = 1;
                for (int j = 1; j <= v.cnt; j++) if (sent[j] != mem[j-1]) ok = 0;
                check(ok, "R4", "data words in order, msb first", 32'(ok), 32'd1);
                check(sent[v.cnt + 1] == 32'd0, "R3", "pad word zero", sent[v.cnt + 1], 32'd0);
            end
        end

        // R6 boundary: 128 registers accepted
        f0 = frames;
        run(8'd128, 16'h4000, 4'h7, 0, seen, perr, lerr);
        check(seen && !perr && !lerr, "R6", "count 128 accepted",
              {29'd0, seen, perr, lerr}, 32'd4);
        check(nbits == 32 * 130, "R3", "128-register frame bits", 32'(nbits), 32'(32 * 130));
        check(sent[0][7:1] == 7'd127, "R1", "length field for 128", 32'(sent[0][7:1]), 32'd127);
        check(sent[128] == mem[127], "R4", "last data word", sent[128], mem[127]);

        // R8 busy timing and R9 start while busy
        for (int j = 0; j < 128; j++) mem[j] = 32'h1111_0000 + 32'(j);
        bad_word = 0;
        f0 = frames;
        @(negedge clk);
        count_i = 8'd2; addr_i = 16'h0A0A; mms_i = 4'h9; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check(busy_o, "R8", "busy after start", 32'(busy_o), 32'd1);
        repeat (100) @(negedge clk);
        count_i = 8'd5; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        while (!done_o) @(negedge clk);
        check(!proto_err_o && !len_err_o, "R9", "first request unaffected",
              {30'd0, proto_err_o, len_err_o}, 32'd0);
        @(negedge clk);
        check(!busy_o, "R8", "idle after done", 32'(busy_o), 32'd0);
        repeat (200) @(negedge clk);
        check(frames == f0 + 1 && nbits == 32 * 4 && !busy_o, "R9",
              "start during busy ignored", 32'(nbits), 32'(32 * 4));

        // R5: MOSI never moved while SCLK was high
        check(mosi_hi_changes == 0, "R5", "mosi stable while sclk high",
              32'(mosi_hi_changes), 32'd0);

        finish_run();
    end

endmodule